// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches eight general-purpose input pins and turns their activity into interrupt requests. Each pin is configured on its own: it can be sensed as a level or as an edge, and it can be active-low/falling or active-high/rising. Edge events are held in a per-pin latch until software acknowledges them by writing a one to that pin's bit in the acknowledge register. Level-sensed pins stay pending for as long as the pin sits at its active level.

Every pin passes through a two-flop synchronizer. An optional per-pin glitch filter then accepts a new pin value only after it has stayed steady for a fixed number of slow filter strobes. A per-pin enable masks the pending bits. One readable register shows the pending bits before masking and another shows them after masking. The single interrupt output is the registered OR of the masked pending bits. Software reaches the registers over a simple byte-wide bus: writes take effect on a clock edge, and reads are combinational from the address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the sense, polarity, enable and filter registers read 0x00, the masked status reads 0x00 and irqOut is 0.
- R2: The registers at byte offsets 0x00 (sense: 1 means edge), 0x04 (polarity: 1 means high/rising), 0x0C (enable) and 0x18 (filter enable) read back the last value written. The acknowledge register at 0x08 and all unmapped offsets read 0x00.
- R3: A pin in level mode (sense bit 0) is pending in the raw status at offset 0x10 while its synchronized level equals its polarity bit (1 means high, 0 means low). This holds whatever the enable bit is.
- R4: A pin in edge mode (sense bit 1) latches a pending event on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0. The edge of the other direction is ignored.
- R5: A latched edge event stays pending until a 1 is written to that pin's bit at offset 0x08. Bits written as 0 leave their pins' events unchanged.
- R6: A write to offset 0x08 has no effect on pins in level mode.
- R7: The masked status at offset 0x14 equals raw status AND enable. While a pin's enable bit is 0, no edge event is captured for it and any event it has latched is discarded.
- R8: irqOut is 1 exactly one clock after the masked status is non-zero.
- R9: With the filter bit of a pin set to 1, a change on the synchronized pin is accepted only after it has held for DEB_STROBES filter strobes in a row. A shorter pulse is never detected, and no change is accepted while the strobe is low.
- R10: When an edge event and an acknowledge for the same pin fall in the same clock, the event remains latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | Asynchronous pin inputs |
| debStrobe | input | 1 | Filter sampling strobe, one clock wide per tick |
| busSel | input | 1 | Bus access select |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr |
| irqOut | output | 1 | Combined interrupt request |

## Verification
An acknowledge for a pin can arrive in the same clock as a new edge event on that pin. If the acknowledge won, that event would be lost silently. The bench provokes this case by timing a rising edge on the pin so that, after the two synchronizer stages, the detected edge lands on the very clock edge that samples an acknowledge write. It expects the pending bit to survive, and it then confirms that a plain acknowledge afterwards does clear the bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PIN_CNT = 8;
  localparam int ADDR_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_SENSE = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_POL   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_EN    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_FILT  = 5'h18;

  typedef struct packed {
    logic [PIN_CNT-1:0] edgeMode;
    logic [PIN_CNT-1:0] highActive;
    logic [PIN_CNT-1:0] enable;
    logic [PIN_CNT-1:0] filterEn;
    logic [PIN_CNT-1:0] ackHit;
  } pinCtl_t;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [PIN_CNT-1:0] busWdata,
  input  logic [PIN_CNT-1:0] rawPend,
  input  logic [PIN_CNT-1:0] statPend,
  output pinCtl_t            ctl,
  output logic [PIN_CNT-1:0] busRdata
);
  logic [PIN_CNT-1:0] senseQ, polQ, enQ, filtQ;
  logic wrEn;

  assign wrEn = busSel && busWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      senseQ <= '0;
      polQ   <= '0;
      enQ    <= '0;
      filtQ  <= '0;
    end else if (wrEn) begin
      case (busAddr)
        OFS_SENSE: senseQ <= busWdata;
        OFS_POL:   polQ   <= busWdata;
        OFS_EN:    enQ    <= busWdata;
        OFS_FILT:  filtQ  <= busWdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl.edgeMode   = senseQ;
    ctl.highActive = polQ;
    ctl.enable     = enQ;
    ctl.filterEn   = filtQ;
    ctl.ackHit     = (wrEn && busAddr == OFS_ACK) ? busWdata : '0;
  end

  always_comb begin
    case (busAddr)
      OFS_SENSE: busRdata = senseQ;
      OFS_POL:   busRdata = polQ;
      OFS_EN:    busRdata = enQ;
      OFS_FILT:  busRdata = filtQ;
      OFS_RAW:   busRdata = rawPend;
      OFS_STAT:  busRdata = statPend;
      default:   busRdata = '0;
    endcase
  end

  // R2: an acknowledge write stores nothing in the configuration
  a_r2_ack_no_store: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr == OFS_ACK) |=> ($stable(senseQ) && $stable(polQ) && $stable(enQ) && $stable(filtQ)));

  // R1: configuration is cleared by reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (senseQ == '0 && enQ == '0 && polQ == '0 && filtQ == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int DEB_STROBES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_CNT-1:0] pinIn,
  input  logic               debStrobe,
  input  pinCtl_t            ctl,
  output logic [PIN_CNT-1:0] rawPend,
  output logic [PIN_CNT-1:0] statPend
);
  localparam int CNT_W = $clog2(DEB_STROBES + 1);

  for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
    logic syncA, syncB, stableQ, prevQ, latchQ, filt, edgeEv, lvlHit;
    logic [CNT_W-1:0] cntQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
      end else begin
        syncA <= pinIn[i];
        syncB <= syncA;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stableQ <= 1'b0;
        cntQ    <= '0;
      end else if (syncB == stableQ) begin
        cntQ <= '0;
      end else if (debStrobe) begin
        if (cntQ == CNT_W'(DEB_STROBES - 1)) begin
          stableQ <= syncB;
          cntQ    <= '0;
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end

    assign filt   = ctl.filterEn[i] ? stableQ : syncB;
    assign lvlHit = ctl.highActive[i] ? filt : ~filt;
    assign edgeEv = ctl.highActive[i] ? (filt & ~prevQ) : (~filt & prevQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevQ  <= 1'b0;
        latchQ <= 1'b0;
      end else begin
        prevQ <= filt;
        if (!ctl.edgeMode[i] || !ctl.enable[i])
          latchQ <= 1'b0;
        else
          latchQ <= (latchQ & ~ctl.ackHit[i]) | edgeEv;
      end
    end

    assign rawPend[i]  = ctl.edgeMode[i] ? latchQ : lvlHit;
    assign statPend[i] = rawPend[i] & ctl.enable[i];

    // R5: a latched event holds without an acknowledge
    a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
      (latchQ && !ctl.ackHit[i] && ctl.enable[i] && ctl.edgeMode[i]) |=> latchQ);
    // R7: disabled pins hold no event
    a_r7_drop: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.enable[i] |=> !latchQ);
    // R10: an edge wins over a same-cycle acknowledge
    a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rstN)
      (edgeEv && ctl.enable[i] && ctl.edgeMode[i]) |=> latchQ);
    // R9: the filtered value moves only on a strobe
    a_r9_strobe_only: assert property (@(posedge clk) disable iff (!rstN)
      !debStrobe |=> $stable(stableQ));
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int DEB_STROBES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_CNT-1:0] pinIn,
  input  logic               debStrobe,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [PIN_CNT-1:0] busWdata,
  output logic [PIN_CNT-1:0] busRdata,
  output logic               irqOut
);
  pinCtl_t ctl;
  logic [PIN_CNT-1:0] rawPend, statPend;

  gpio_irq_regs i_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .rawPend(rawPend),
    .statPend(statPend), .ctl(ctl), .busRdata(busRdata)
  );

  gpio_irq_detect #(.DEB_STROBES(DEB_STROBES)) i_detect (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .debStrobe(debStrobe),
    .ctl(ctl), .rawPend(rawPend), .statPend(statPend)
  );

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |statPend;
  end

  // R8: irqOut follows the masked status one clock later
  a_r8_irq_follow: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|statPend)));
endmodule

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/100ps
module test_gpio_irq_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pinIn = '0;
  logic debStrobe = 1'b1;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic irqOut;
  int checks = 0, errs = 0;
  bit done = 0;

  gpio_irq_ctrl #(.DEB_STROBES(4)) i_gpio_irq_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .debStrobe(debStrobe),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic chkReg(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] model, prevP, p, m, expRaw;
    tick(3);
    rstN = 1'b1;
    tick(3);
    // R1 reset state
    chkReg("R1 sense", 5'h00, 8'h00);
    chkReg("R1 pol", 5'h04, 8'h00);
    chkReg("R1 en", 5'h0C, 8'h00);
    chkReg("R1 filt", 5'h18, 8'h00);
    chkReg("R1 stat", 5'h14, 8'h00);
    chk("R1 irq", {7'd0, irqOut}, 8'h00);
    chkReg("R3 low level raw", 5'h10, 8'hFF);

    // R2 readback
    wr(5'h00, 8'hA5); wr(5'h04, 8'h3C); wr(5'h18, 8'h0F); wr(5'h0C, 8'h81);
    chkReg("R2 sense", 5'h00, 8'hA5);
    chkReg("R2 pol", 5'h04, 8'h3C);
    chkReg("R2 filt", 5'h18, 8'h0F);
    chkReg("R2 en", 5'h0C, 8'h81);
    chkReg("R2 ack", 5'h08, 8'h00);
    chkReg("R2 unmapped", 5'h1C, 8'h00);
    wr(5'h0C, 8'h00); wr(5'h00, 8'h00); wr(5'h04, 8'h00); wr(5'h18, 8'h00);

    // Sweep over the four sense/polarity modes
    for (int mode = 0; mode < 4; mode++) begin
      wr(5'h0C, 8'h00);
      wr(5'h00, mode[1] ? 8'hFF : 8'h00);
      wr(5'h04, mode[0] ? 8'hFF : 8'h00);
      wr(5'h0C, 8'hFF);
      model = 8'h00;
      prevP = pinIn;
      for (int k = 0; k < 8; k++) begin
        p = (k == 0) ? 8'hFF : (k == 1) ? 8'h00 : (8'(k * 53) ^ 8'h96 ^ 8'(mode * 17));
        pinIn = p;
        if (mode[0]) model |= p & ~prevP;
        else         model |= ~p & prevP;
        prevP = p;
        tick(5);
        expRaw = mode[1] ? model : (mode[0] ? p : ~p);
        chkReg(mode[1] ? "R4 edge raw" : "R3 level raw", 5'h10, expRaw);
        chkReg("R7 masked", 5'h14, expRaw);
        chk("R8 irq", {7'd0, irqOut}, {7'd0, |expRaw});
        m = 8'h0F ^ 8'(k * 29);
        wr(5'h08, m);
        tick(2);
        if (mode[1]) begin
          model &= ~m;
          chkReg("R5 ack clears written ones only", 5'h10, model);
        end else begin
          chkReg("R6 ack ignored on level", 5'h10, mode[0] ? p : ~p);
        end
      end
    end

    // R7: enable masking and discard
    wr(5'h0C, 8'h00); wr(5'h00, 8'h00); wr(5'h04, 8'hFF);
    pinIn = 8'hF0; wr(5'h0C, 8'h3C); tick(4);
    chkReg("R7 masked level", 5'h14, 8'h30);
    chkReg("R3 raw ignores enable", 5'h10, 8'hF0);
    wr(5'h0C, 8'h00);
    pinIn = 8'h00; wr(5'h00, 8'hFF); wr(5'h0C, 8'hFF); tick(4);
    wr(5'h08, 8'hFF);
    pinIn = 8'h01; tick(5);
    chkReg("R4 rise latched", 5'h10, 8'h01);
    wr(5'h0C, 8'h00); tick(2); wr(5'h0C, 8'hFF); tick(2);
    chkReg("R7 disable discards", 5'h10, 8'h00);
    wr(5'h0C, 8'h00); pinIn = 8'h03; tick(5); wr(5'h0C, 8'hFF); tick(3);
    chkReg("R7 no capture disabled", 5'h10, 8'h00);
    chk("R8 irq idle", {7'd0, irqOut}, 8'h00);

    // R10: edge and acknowledge in the same clock
    pinIn = 8'h00; tick(5);
    wr(5'h08, 8'hFF);
    pinIn = 8'h01; tick(5);
    chkReg("R10 setup", 5'h10, 8'h01);
    pinIn = 8'h00; tick(5);
    pinIn = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 5'h08; busWdata = 8'h01;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    tick(2);
    chkReg("R10 edge wins", 5'h10, 8'h01);
    wr(5'h08, 8'h01); tick(2);
    chkReg("R5 plain ack clears", 5'h10, 8'h00);

    // R9: filter
    pinIn = 8'h00; wr(5'h18, 8'hFF); tick(10); wr(5'h08, 8'hFF); tick(2);
    pinIn = 8'h04; tick(2); pinIn = 8'h00; tick(10);
    chkReg("R9 short pulse rejected", 5'h10, 8'h00);
    pinIn = 8'h04; tick(6); pinIn = 8'h00; tick(10);
    chkReg("R9 long pulse accepted", 5'h10, 8'h04);
    wr(5'h08, 8'hFF); tick(10);
    debStrobe = 1'b0;
    pinIn = 8'h08; tick(20);
    chkReg("R9 no strobe no accept", 5'h10, 8'h00);
    debStrobe = 1'b1; tick(10);
    chkReg("R9 accepted after strobes", 5'h10, 8'h08);
    pinIn = 8'h00; tick(10);
    wr(5'h18, 8'h00); wr(5'h08, 8'hFF); tick(2);
    pinIn = 8'h10; tick(2); pinIn = 8'h00; tick(6);
    chkReg("R9 filter off passes pulse", 5'h10, 8'h10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule